// File: doc/BRIEF.md
# SPI Ferroelectric Memory Command Sequencer

This block is an SPI master that carries out whole transactions against a serial ferroelectric memory on behalf of a host. The host starts a command by pulsing `cmd_start` with a command select, a memory address, a byte count and a fill byte. The sequencer then drives chip select low and sends the opcode. For memory commands it follows with the address, most significant byte first. Last it moves the data bytes. Write data comes in on a byte-wide valid/ready stream. Read, status and identifier bytes go out on a second byte-wide valid/ready stream. The SPI clock stalls low, with chip select held, whenever either stream applies back-pressure.

After reset the sequencer identifies the attached device without being asked. It takes five bits of the third identifier byte as a density code and chooses from it whether the memory needs a two-byte or a three-byte address. All later memory commands use that width. The shift engine runs SPI mode 0 with a fixed clock divider.

Top module: `fram_cmd_seq`

## Requirements
- R1: The SPI link runs mode 0. `spi_sclk` is low whenever no byte is moving. `spi_mosi` changes only while `spi_sclk` is low. Every byte is eight clocks, most significant bit first, and each received bit is taken on the rising edge.
- R2: `spi_cs_n` is high while idle and stays low from before the first clock of a transaction until after its last byte. `busy` falls exactly one cycle after `spi_cs_n` rises. `spi_sclk` never pulses while `spi_cs_n` is high.
- R3: Out of reset, `busy` is high and the block runs one identify transaction with no host command: byte 0x9F followed by four 0x00 bytes. Nothing appears on the read stream during this transaction.
- R4: Bits [4:0] of the third identifier byte received at start-up form a density code. If the code is greater than `DENS_LIMIT`, `addr24` becomes 1; otherwise it is 0. Bits [7:5] of that byte are ignored.
- R5: After the opcode, memory commands send the address most significant byte first: bytes [23:16], [15:8], [7:0] when `addr24` is 1, and only [15:8], [7:0] when it is 0.
- R6: Read (`cmd_sel` 0, opcode 0x03) sends `cmd_len` zero bytes after the address, under a single chip-select assertion. Each captured byte is offered in order on `rd_data`/`rd_valid` and is held stable until `rd_ready` accepts it.
- R7: Write (`cmd_sel` 1, opcode 0x02) sends `cmd_len` bytes taken one per `wr_valid`/`wr_ready` handshake. While the stream is empty, the link waits with the clock low and chip select low.
- R8: Fill (`cmd_sel` 2, opcode 0x02) sends `cmd_fill` `cmd_len` times after the address and does not use the write stream.
- R9: Read status (`cmd_sel` 3, opcode 0x05) sends one zero byte after the opcode and delivers the captured byte as one read-stream item.
- R10: Write enable (`cmd_sel` 4, opcode 0x06) and write disable (`cmd_sel` 5, opcode 0x04) are transactions of the opcode byte alone.
- R11: Identify (`cmd_sel` 6, opcode 0x9F) sends four zero bytes and delivers the four captured bytes as read-stream items. It leaves `addr24` unchanged.
- R12: A `cmd_len` of zero makes read, write and fill send only the opcode and the address bytes.
- R13: `cmd_start` is ignored while `busy` is high, and `cmd_sel` 7 is ignored at all times: neither starts a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle command request, taken only when not busy |
| cmd_sel | input | 3 | Command select (0 read, 1 write, 2 fill, 3 status, 4 write enable, 5 write disable, 6 identify, 7 none) |
| cmd_addr | input | 24 | Start address of a memory command |
| cmd_len | input | LEN_W | Data byte count for read, write and fill |
| cmd_fill | input | 8 | Byte repeated by a fill command |
| busy | output | 1 | High from reset or command acceptance until the cycle after chip select rises |
| addr24 | output | 1 | Address width chosen at start-up: 1 = three bytes, 0 = two bytes |
| wr_data | input | 8 | Write stream data |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| rd_data | output | 8 | Read stream data |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | SPI data to the memory |
| spi_miso | input | 1 | SPI data from the memory |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the sequencer with `CLK_DIV` = 2 and `LEN_W` = 4. This keeps each byte at 32 cycles and limits the count to 0..15, so a sweep of every length from 0 to 5 for writes, fills and reads stays short. A behavioural memory model answers on the SPI pins, and the bench reset-cycles the design twice. Its identifier reports density codes 5 (with the upper bits set) and 6. These fall on either side of `DENS_LIMIT` = 5, which puts both address widths and the boundary of the width decision within reach.

// File: rtl/fram_seq_pkg.sv
package fram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_READ   = 3'd0,
    CMD_WRITE  = 3'd1,
    CMD_FILL   = 3'd2,
    CMD_STATUS = 3'd3,
    CMD_WEN    = 3'd4,
    CMD_WDIS   = 3'd5,
    CMD_IDENT  = 3'd6,
    CMD_NONE   = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_LOAD, ST_XFER, ST_WRWAIT, ST_RDPUSH, ST_CSOFF
  } seq_st_e;

  typedef enum logic [1:0] {
    STG_OPC, STG_ADR, STG_DAT
  } stage_e;

  function automatic logic [7:0] opcode_of(cmd_e c);
    case (c)
      CMD_READ:   opcode_of = 8'h03;
      CMD_WRITE:  opcode_of = 8'h02;
      CMD_FILL:   opcode_of = 8'h02;
      CMD_STATUS: opcode_of = 8'h05;
      CMD_WEN:    opcode_of = 8'h06;
      CMD_WDIS:   opcode_of = 8'h04;
      CMD_IDENT:  opcode_of = 8'h9F;
      default:    opcode_of = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CLK_DIV - 1);

  logic             active;
  logic [CNT_W-1:0] div;
  logic [2:0]       bitn;
  logic [7:0]       tsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div     <= '0;
      bitn    <= '0;
      tsh     <= '0;
      rx_byte <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          tsh    <= tx_byte;
          mosi   <= tx_byte[7];
          bitn   <= '0;
          div    <= '0;
          sclk   <= 1'b0;
        end
      end else if (div == DIV_LAST) begin
        div <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            tsh  <= {tsh[6:0], 1'b0};
            mosi <= tsh[6];
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  // R1: data is held steady across the high phase of the clock
  p_mosi_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R1: a byte ends with the clock back at its idle level
  p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sclk && !active));

endmodule

// File: rtl/fram_seq_ctrl.sv
module fram_seq_ctrl
  import fram_seq_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int DENS_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [2:0]       cmd_sel,
  input  logic [23:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       cmd_fill,
  output logic             busy,
  output logic             addr24,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             cs_n,
  output logic             sh_start,
  output logic [7:0]       sh_tx,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx
);
  localparam int CW = (LEN_W > 3) ? LEN_W : 3;
  localparam logic [4:0] DLIM = 5'(DENS_LIMIT);

  seq_st_e      st;
  stage_e       stg;
  cmd_e         cur;
  cmd_e         sel_c;
  logic [23:0]  addr_q;
  logic [7:0]   fill_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] load_cnt;
  logic [1:0]   alen;
  logic [1:0]   idx;
  logic         boot;
  logic         has_addr;
  logic         is_rx;
  logic [7:0]   adr_byte;

  assign sel_c = cmd_e'(cmd_sel);

  always_comb begin
    has_addr = (cur == CMD_READ) || (cur == CMD_WRITE) || (cur == CMD_FILL);
    is_rx    = (cur == CMD_READ) || (cur == CMD_STATUS) || (cur == CMD_IDENT);
    case (alen)
      2'd3:    adr_byte = addr_q[23:16];
      2'd2:    adr_byte = addr_q[15:8];
      default: adr_byte = addr_q[7:0];
    endcase
    case (sel_c)
      CMD_READ, CMD_WRITE, CMD_FILL: load_cnt = CW'(cmd_len);
      CMD_STATUS:                    load_cnt = CW'(1);
      CMD_IDENT:                     load_cnt = CW'(4);
      default:                       load_cnt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_BOOT;
      stg      <= STG_OPC;
      cur      <= CMD_IDENT;
      busy     <= 1'b1;
      cs_n     <= 1'b1;
      addr24   <= 1'b0;
      boot     <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wr_ready <= 1'b0;
      sh_start <= 1'b0;
      sh_tx    <= '0;
      addr_q   <= '0;
      fill_q   <= '0;
      cnt      <= '0;
      alen     <= '0;
      idx      <= '0;
    end else begin
      sh_start <= 1'b0;
      case (st)
        ST_BOOT: begin
          cs_n <= 1'b0;
          cur  <= CMD_IDENT;
          stg  <= STG_OPC;
          cnt  <= CW'(4);
          idx  <= '0;
          st   <= ST_LOAD;
        end
        ST_IDLE: begin
          if (cmd_start && sel_c != CMD_NONE) begin
            busy   <= 1'b1;
            cs_n   <= 1'b0;
            cur    <= sel_c;
            addr_q <= cmd_addr;
            fill_q <= cmd_fill;
            stg    <= STG_OPC;
            idx    <= '0;
            cnt    <= load_cnt;
            st     <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          case (stg)
            STG_OPC: begin
              sh_tx    <= opcode_of(cur);
              sh_start <= 1'b1;
              st       <= ST_XFER;
            end
            STG_ADR: begin
              sh_tx    <= adr_byte;
              sh_start <= 1'b1;
              st       <= ST_XFER;
            end
            default: begin
              if (cnt == '0) begin
                cs_n <= 1'b1;
                st   <= ST_CSOFF;
              end else if (cur == CMD_WRITE) begin
                wr_ready <= 1'b1;
                st       <= ST_WRWAIT;
              end else begin
                sh_tx    <= (cur == CMD_FILL) ? fill_q : 8'h00;
                sh_start <= 1'b1;
                st       <= ST_XFER;
              end
            end
          endcase
        end
        ST_WRWAIT: begin
          if (wr_valid) begin
            wr_ready <= 1'b0;
            sh_tx    <= wr_data;
            sh_start <= 1'b1;
            st       <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (sh_done) begin
            case (stg)
              STG_OPC: begin
                if (has_addr) begin
                  stg  <= STG_ADR;
                  alen <= addr24 ? 2'd3 : 2'd2;
                end else begin
                  stg <= STG_DAT;
                end
                st <= ST_LOAD;
              end
              STG_ADR: begin
                alen <= alen - 2'd1;
                if (alen == 2'd1) stg <= STG_DAT;
                st <= ST_LOAD;
              end
              default: begin
                cnt <= cnt - 1'b1;
                idx <= idx + 2'd1;
                if (boot) begin
                  if (idx == 2'd2) addr24 <= (sh_rx[4:0] > DLIM);
                  st <= ST_LOAD;
                end else if (is_rx) begin
                  rd_data  <= sh_rx;
                  rd_valid <= 1'b1;
                  st       <= ST_RDPUSH;
                end else begin
                  st <= ST_LOAD;
                end
              end
            endcase
          end
        end
        ST_RDPUSH: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            st       <= ST_LOAD;
          end
        end
        ST_CSOFF: begin
          busy <= 1'b0;
          boot <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: an offered read byte stays put until taken
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R7: a pending write request waits for the stream
  p_wr_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && !wr_valid) |=> wr_ready);

  // R13: with no command in progress the memory is deselected
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  // R3: the start-up identify never feeds the read stream
  p_boot_silent_r3: assert property (@(posedge clk) disable iff (rst)
    boot |-> !rd_valid);

endmodule

// File: rtl/fram_cmd_seq.sv
module fram_cmd_seq #(
  parameter int CLK_DIV    = 4,
  parameter int LEN_W      = 8,
  parameter int DENS_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [2:0]       cmd_sel,
  input  logic [23:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       cmd_fill,
  output logic             busy,
  output logic             addr24,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);
  logic       sh_start;
  logic [7:0] sh_tx;
  logic       sh_done;
  logic [7:0] sh_rx;

  fram_seq_ctrl #(
    .LEN_W      (LEN_W),
    .DENS_LIMIT (DENS_LIMIT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .cmd_sel   (cmd_sel),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_fill  (cmd_fill),
    .busy      (busy),
    .addr24    (addr24),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .cs_n      (spi_cs_n),
    .sh_start  (sh_start),
    .sh_tx     (sh_tx),
    .sh_done   (sh_done),
    .sh_rx     (sh_rx)
  );

  spi_byte_shift #(
    .CLK_DIV (CLK_DIV)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  // R2: no clock edge reaches a deselected memory
  p_sclk_needs_cs_r2: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n);

  // R2: busy clears on the cycle after deselect
  p_busy_after_cs_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> !busy);

  // R2: deselect is only ever raised while still busy
  p_cs_rise_busy_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> busy);

endmodule

// File: tb/tb_fram_cmd_seq.sv
module tb_fram_cmd_seq;
  localparam int CLK_DIV = 2;
  localparam int LEN_W   = 4;
  localparam int DLIM    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 1'b0;
  logic [2:0] cmd_sel = 3'd7;
  logic [23:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [7:0] cmd_fill = '0;
  logic busy, addr24, wr_ready, rd_valid, spi_sclk, spi_mosi, spi_cs_n;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0;
  logic [7:0] rd_data;
  logic rd_ready = 1'b0;
  logic spi_miso = 1'b0;

  always #5 clk = ~clk;

  fram_cmd_seq #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .DENS_LIMIT(DLIM)) dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_sel(cmd_sel),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_fill(cmd_fill),
    .busy(busy), .addr24(addr24), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int nvec = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- memory model on the SPI pins ----------------
  logic [7:0] mem [0:4095];
  logic [7:0] dens_byte = 8'hE5;
  logic [7:0] txlog [0:31];
  int log_n = 0;
  int txn_cnt = 0;
  int m_bits = 0, m_idx = 0;
  logic [7:0] m_sh = '0, m_op = '0, m_pend = '0, m_out = '0;
  logic [23:0] m_a = '0;
  bit m_load = 0, m_wel = 0;

  function automatic logic [7:0] id_byte(input int i, input logic [7:0] d);
    case (i)
      0: id_byte = 8'h04;
      1: id_byte = 8'h7F;
      2: id_byte = d;
      3: id_byte = 8'h03;
      default: id_byte = 8'h00;
    endcase
  endfunction

  task automatic m_byte(input logic [7:0] b);
    int nab;
    nab = (dens_byte[4:0] > 5'd5) ? 3 : 2;
    if (log_n < 32) txlog[log_n] = b;
    log_n++;
    m_pend = 8'h00;
    if (m_idx == 0) begin
      m_op = b;
      m_a = '0;
      if (b == 8'h06) m_wel = 1;
      if (b == 8'h04) m_wel = 0;
    end
    case (m_op)
      8'h9F: m_pend = id_byte(m_idx, dens_byte);
      8'h05: m_pend = {6'b0, m_wel, 1'b0};
      8'h03: begin
        if (m_idx >= 1 && m_idx <= nab) m_a = {m_a[15:0], b};
        if (m_idx == nab) m_pend = mem[m_a[11:0]];
        else if (m_idx > nab) begin m_a = m_a + 1; m_pend = mem[m_a[11:0]]; end
      end
      8'h02: begin
        if (m_idx >= 1 && m_idx <= nab) m_a = {m_a[15:0], b};
        else if (m_idx > nab) begin
          if (m_wel) mem[m_a[11:0]] = b;
          m_a = m_a + 1;
        end
      end
      default: ;
    endcase
    m_load = 1;
    m_idx++;
  endtask

  initial forever begin
    @(negedge spi_cs_n);
    m_bits = 0; m_idx = 0; m_load = 0; log_n = 0; txn_cnt++;
  end
  initial forever begin
    @(posedge spi_sclk);
    m_sh = {m_sh[6:0], spi_mosi};
    m_bits++;
    if (m_bits == 8) begin m_bits = 0; m_byte(m_sh); end
  end
  initial forever begin
    @(negedge spi_sclk);
    if (m_load) begin m_out = m_pend; m_load = 0; end
    else m_out = {m_out[6:0], 1'b0};
    spi_miso = m_out[7];
  end

  // ---------------- streams and pin monitors ----------------
  logic [7:0] wq [0:15];
  int wr_n = 0, wr_ptr = 0;
  logic [7:0] rq [0:15];
  int rq_n = 0;
  int cyc = 0;
  bit whs = 0, rhs = 0;
  logic [7:0] rcap = '0;
  logic p_sclk = 0, p_mosi = 0, p_cs = 1, rise_seen = 0;
  int r1_viol = 0, r2_viol = 0;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (whs) wr_ptr++;
    wr_valid = (wr_ptr < wr_n) && (cyc % 3 != 0);
    wr_data  = wq[wr_ptr % 16];
    whs = wr_valid && wr_ready;
    if (rhs) begin if (rq_n < 16) rq[rq_n] = rcap; rq_n++; end
    rd_ready = (cyc % 4 != 1);
    rhs = rd_valid && rd_ready;
    rcap = rd_data;
    if (!rst) begin
      if (p_sclk && spi_sclk && (spi_mosi != p_mosi)) r1_viol++;
      if (spi_sclk && spi_cs_n) r2_viol++;
      if (rise_seen && busy) r2_viol++;
      rise_seen = (!p_cs && spi_cs_n);
      if (rise_seen && !busy) r2_viol++;
    end
    p_sclk = spi_sclk; p_mosi = spi_mosi; p_cs = spi_cs_n;
  end

  // ---------------- expectations ----------------
  logic [7:0] emem [0:4095];
  logic [7:0] elog [0:31];
  int e_n = 0;
  bit e_wel = 0;
  bit e_a24 = 0;

  function automatic logic [7:0] op_exp(input int s);
    case (s)
      0: op_exp = 8'h03; 1: op_exp = 8'h02; 2: op_exp = 8'h02; 3: op_exp = 8'h05;
      4: op_exp = 8'h06; 5: op_exp = 8'h04; default: op_exp = 8'h9F;
    endcase
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0: req_of = "R6"; 1: req_of = "R7"; 2: req_of = "R8"; 3: req_of = "R9";
      4, 5: req_of = "R10"; default: req_of = "R11";
    endcase
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_log(input string req);
    int bad;
    bad = -1;
    if (log_n != e_n) bad = 99;
    else for (int i = 0; i < e_n; i++) if (bad < 0 && txlog[i] != elog[i]) bad = i;
    if (bad == 99) chk(0, {req, " frame length"}, log_n, e_n);
    else if (bad >= 0) chk(0, {req, " frame byte"}, txlog[bad], elog[bad]);
    else chk(1, req, 0, 0);
  endtask

  task automatic run(input int s, input logic [23:0] a, input int len, input logic [7:0] f);
    int nd;
    e_n = 0;
    elog[e_n++] = op_exp(s);
    if (s <= 2) begin
      if (e_a24) elog[e_n++] = a[23:16];
      elog[e_n++] = a[15:8];
      elog[e_n++] = a[7:0];
    end
    nd = (s <= 2) ? len : (s == 3) ? 1 : (s == 6) ? 4 : 0;
    for (int i = 0; i < nd; i++)
      elog[e_n++] = (s == 1) ? wq[i] : (s == 2) ? f : 8'h00;
    wr_ptr = 0; wr_n = (s == 1) ? len : 0; rq_n = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    cmd_sel = 3'(s); cmd_addr = a; cmd_len = LEN_W'(len); cmd_fill = f; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_idle();
    check_log({req_of(s), (s <= 2) ? "/R5" : "", (len == 0 && s <= 2) ? "/R12" : ""});
    if (s == 0 || s == 3 || s == 6) begin
      int bad;
      logic [7:0] ev [0:15];
      for (int i = 0; i < nd; i++)
        ev[i] = (s == 0) ? emem[12'(a[11:0] + i)] :
                (s == 3) ? {6'b0, e_wel, 1'b0} : id_byte(i, dens_byte);
      bad = -1;
      if (rq_n != nd) chk(0, {req_of(s), " read count"}, rq_n, nd);
      else begin
        for (int i = 0; i < nd; i++) if (bad < 0 && rq[i] != ev[i]) bad = i;
        if (bad >= 0) chk(0, {req_of(s), " read data"}, rq[bad], ev[bad]);
        else chk(1, req_of(s), 0, 0);
      end
    end else begin
      chk(rq_n == 0, {req_of(s), " no read items"}, rq_n, 0);
    end
    if ((s == 1 || s == 2) && e_wel)
      for (int i = 0; i < len; i++) emem[12'(a[11:0] + i)] = (s == 1) ? wq[i] : f;
    if (s == 4) e_wel = 1;
    if (s == 5) e_wel = 0;
  endtask

  task automatic do_reset(input logic [7:0] d);
    dens_byte = d;
    e_a24 = (d[4:0] > 5'(DLIM));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && busy == 1'b1 && rd_valid == 1'b0 && wr_ready == 1'b0,
        "R2/R3 reset state", {spi_cs_n, spi_sclk, busy, rd_valid, wr_ready}, 5'b10100);
    rq_n = 0;
    rst = 1'b0;
    @(negedge clk);
    wait_idle();
    e_n = 5; elog[0] = 8'h9F;
    for (int i = 1; i < 5; i++) elog[i] = 8'h00;
    check_log("R3 identify at start-up");
    chk(rq_n == 0, "R3 no read items at start-up", rq_n, 0);
    chk(addr24 == e_a24, "R4 address width", addr24, e_a24);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (all requirements): got 0 expected 1");
    finish_run();
  end

  initial begin
    int t0;
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = 8'(i) ^ 8'h3C;
      emem[i] = 8'(i) ^ 8'h3C;
    end
    m_wel = 0;
    e_wel = 0;

    // Two-byte addressing: density code 5 (limit), upper bits set
    do_reset(8'hE5);
    for (int i = 0; i < 8; i++) wq[i] = 8'(8'hC1 + 8'(i * 29));
    run(5, 24'h00_0000, 0, 8'h00);
    run(1, 24'h7E_0120, 2, 8'h00);            // R10: write disabled, no change
    run(0, 24'h7E_0120, 2, 8'h00);
    run(4, 24'h00_0000, 0, 8'h00);
    run(3, 24'h00_0000, 0, 8'h00);
    for (int len = 0; len < 6; len++) begin
      for (int i = 0; i < 8; i++) wq[i] = 8'(len * 37 + i * 11 + 5);
      run(1, 24'h5A_A300 + 24'(len * 16), len, 8'h00);
      run(2, 24'h5A_A800 + 24'(len * 16), len, 8'h5A ^ 8'(len));
    end
    for (int len = 0; len < 6; len++) begin
      run(0, 24'h5A_A300 + 24'(len * 16), len, 8'h00);
      run(0, 24'h5A_A800 + 24'(len * 16), 6, 8'h00);
    end
    run(6, 24'h00_0000, 0, 8'h00);
    chk(addr24 == 1'b0, "R11 identify keeps width", addr24, 0);

    // R13: command while busy is dropped
    t0 = txn_cnt;
    wr_n = 0; rq_n = 0;
    @(negedge clk);
    cmd_sel = 3'd5; cmd_addr = 24'h00_0040; cmd_len = 4'd4; cmd_sel = 3'd0; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (40) @(negedge clk);
    cmd_sel = 3'd5; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_idle();
    chk(txn_cnt == t0 + 1, "R13 busy refusal transactions", txn_cnt - t0, 1);
    run(3, 24'h0, 0, 8'h00);

    // R13: select 7 never starts a transaction
    t0 = txn_cnt;
    @(negedge clk);
    cmd_sel = 3'd7; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (10) @(negedge clk);
    chk(txn_cnt == t0 && busy == 1'b0 && spi_cs_n == 1'b1, "R13 select 7 ignored", txn_cnt - t0, 0);

    // Three-byte addressing: density code 6, just above the limit
    do_reset(8'h26);
    run(4, 24'h0, 0, 8'h00);
    for (int len = 1; len < 4; len++) begin
      for (int i = 0; i < 8; i++) wq[i] = 8'(len * 71 + i * 3);
      run(1, 24'hC3_5B00 + 24'(len * 32), len, 8'h00);
      run(0, 24'hC3_5B00 + 24'(len * 32), len, 8'h00);
    end
    run(2, 24'h81_0F70, 0, 8'hEE);
    run(0, 24'h81_0F70, 3, 8'h00);

    chk(r1_viol == 0, "R1 data steady while clock high", r1_viol, 0);
    chk(r2_viol == 0, "R2 select framing and busy release", r2_viol, 0);
    finish_run();
  end

endmodule